// File: doc/BRIEF.md
# Adaptive Half-Bridge Gate Interlock

This block sits between a PWM source and the two gate drivers of a half-bridge. It takes one drive command for the high-side switch and one for the low-side switch. It produces a registered enable for each gate, and the two enables are never high at the same time. No fixed dead-time counter is used. Before a gate is enabled, the block waits until a digital flag from the opposite gate shows that gate has actually discharged below its off threshold. The transition therefore adapts to whatever MOSFETs and gate resistors are fitted.

Two supply monitors gate the outputs, and each has a different reach. A main-supply undervoltage flag forces both enables off, and its value is reported on a status output. A floating (bootstrap) supply undervoltage flag blocks only the high-side gate, so the low side keeps switching and can recharge the bootstrap capacitor. Every input is asynchronous and passes through a two-flop synchronizer. The undervoltage flags already include their own hysteresis. An optional watchdog raises a fault while a pending turn-on has waited too long for the opposite gate to discharge.

Top module: `hb_interlock`

## Requirements
- R1: gate_hi_en and gate_lo_en are never both 1. With cmd_hi=1 and cmd_lo=1, both enables are held at 0.
- R2: Both channels are non-inverting. cmd_hi=1 with cmd_lo=0 enables only the high gate, cmd_lo=1 with cmd_hi=0 enables only the low gate, and both commands at 0 turns both gates off.
- R3: When the command swaps from one gate to the other, the gate that is on is turned off first. Both enables are 0 for at least one cycle before the other gate is enabled.
- R4: The high gate is enabled only once lo_gate_dis=1 (low gate discharged). The low gate is enabled only once hi_gate_dis=1 (high gate discharged). While the flag reads 0, the request stays pending.
- R5: While main_uv=1, both enables are 0.
- R6: While float_uv=1, gate_hi_en is 0, but the low channel still follows its command.
- R7: uv_status equals main_uv, delayed by the input latency of R8.
- R8: A change on any input reaches the outputs on the third rising clock edge after it is applied: two synchronizer flops, then the output register.
- R9: tmo_fault is 1 while a turn-on request is still pending after TIMEOUT_CYC full cycles of waiting for the opposite discharge flag. It returns to 0 in the cycle the wait ends. It is 0 whenever a gate is enabled.
- R10: After synchronous reset, both enables are 0, tmo_fault is 0 and uv_status is 1. During reset, the synchronizers treat both undervoltage flags as asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi | input | 1 | High-side drive command, active high |
| cmd_lo | input | 1 | Low-side drive command, active high |
| hi_gate_dis | input | 1 | 1 = high-side gate is below its off threshold |
| lo_gate_dis | input | 1 | 1 = low-side gate is below its off threshold |
| main_uv | input | 1 | 1 = main supply in undervoltage |
| float_uv | input | 1 | 1 = floating high-side supply in undervoltage |
| gate_hi_en | output | 1 | High-side gate enable |
| gate_lo_en | output | 1 | Low-side gate enable |
| uv_status | output | 1 | Main-supply undervoltage indication |
| tmo_fault | output | 1 | Discharge wait has exceeded TIMEOUT_CYC |

## Verification
The assertions check, on every cycle, the properties that hold from one cycle to the next:
- the enables are mutually exclusive;
- an enable rises only after the opposite gate was off and its discharge flag was seen high;
- the two undervoltage flags block the gates they cover;
- a timeout fault never coincides with an enabled gate.

Only the bench's scenarios can show the rest, by comparing against its reference model on every clock:
- the exact three-edge latency;
- that a request stays pending as long as its flag stays low;
- that the low channel keeps working under floating-supply undervoltage;
- when the fault rises and falls;
- the status output.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_HOLD_LO  = 3'd1,  // high requested, low gate not yet discharged
    ST_HI_ON    = 3'd2,
    ST_HOLD_HI  = 3'd3,  // low requested, high gate not yet discharged
    ST_LO_ON    = 3'd4
  } hb_state_t;

  // synchronized input vector bit positions
  localparam int B_CMD_HI = 0;
  localparam int B_CMD_LO = 1;
  localparam int B_HI_DIS = 2;
  localparam int B_LO_DIS = 3;
  localparam int B_FLT_UV = 4;
  localparam int B_MAIN_UV = 5;
  localparam int NUM_IN = 6;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s_cmd_hi,
  input  logic s_cmd_lo,
  input  logic s_hi_dis,
  input  logic s_lo_dis,
  input  logic s_main_uv,
  input  logic s_float_uv,
  output logic gate_hi_en,
  output logic gate_lo_en,
  output logic wait_nxt
);
  hb_state_t st_q, st_d;
  logic want_hi, want_lo;

  // each command is ignored while the other is high; lockouts differ in reach
  assign want_hi = s_cmd_hi & ~s_cmd_lo & ~s_main_uv & ~s_float_uv;
  assign want_lo = s_cmd_lo & ~s_cmd_hi & ~s_main_uv;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (want_hi)      st_d = s_lo_dis ? ST_HI_ON : ST_HOLD_LO;
        else if (want_lo) st_d = s_hi_dis ? ST_LO_ON : ST_HOLD_HI;
      end
      ST_HOLD_LO: begin
        if (!want_hi)     st_d = ST_IDLE;
        else if (s_lo_dis) st_d = ST_HI_ON;
      end
      ST_HI_ON:   if (!want_hi) st_d = ST_IDLE;
      ST_HOLD_HI: begin
        if (!want_lo)     st_d = ST_IDLE;
        else if (s_hi_dis) st_d = ST_LO_ON;
      end
      ST_LO_ON:   if (!want_lo) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  assign wait_nxt = (st_d == ST_HOLD_LO) || (st_d == ST_HOLD_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      gate_hi_en <= 1'b0;
      gate_lo_en <= 1'b0;
    end else begin
      st_q       <= st_d;
      gate_hi_en <= (st_d == ST_HI_ON);
      gate_lo_en <= (st_d == ST_LO_ON);
    end
  end

  p_never_both_r1: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi_en && gate_lo_en));

  p_off_before_lo_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo_en) |-> !$past(gate_hi_en));

  p_off_before_hi_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi_en) |-> !$past(gate_lo_en));

  p_hi_waits_flag_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi_en) |-> $past(s_lo_dis));

  p_lo_waits_flag_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo_en) |-> $past(s_hi_dis));

  p_main_uv_off_r5: assert property (@(posedge clk) disable iff (rst)
    $past(s_main_uv) |-> (!gate_hi_en && !gate_lo_en));

  p_float_uv_hi_off_r6: assert property (@(posedge clk) disable iff (rst)
    $past(s_float_uv) |-> !gate_hi_en);
endmodule

// File: rtl/hb_timeout.sv
module hb_timeout #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic waiting,
  output logic fault
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      fault <= 1'b0;
    end else begin
      if (!waiting)           cnt_q <= '0;
      else if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
      fault <= waiting && (cnt_q == LIM_V);
    end
  end
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_EN  = 1,
  parameter int TIMEOUT_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_hi,
  input  logic cmd_lo,
  input  logic hi_gate_dis,
  input  logic lo_gate_dis,
  input  logic main_uv,
  input  logic float_uv,
  output logic gate_hi_en,
  output logic gate_lo_en,
  output logic uv_status,
  output logic tmo_fault
);
  localparam logic [NUM_IN-1:0] SYNC_RST =
    (NUM_IN'(1) << B_MAIN_UV) | (NUM_IN'(1) << B_FLT_UV);

  logic [NUM_IN-1:0] raw, syn;
  logic wait_nxt;

  assign raw[B_CMD_HI]  = cmd_hi;
  assign raw[B_CMD_LO]  = cmd_lo;
  assign raw[B_HI_DIS]  = hi_gate_dis;
  assign raw[B_LO_DIS]  = lo_gate_dis;
  assign raw[B_FLT_UV]  = float_uv;
  assign raw[B_MAIN_UV] = main_uv;

  hb_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  hb_fsm u_fsm (
    .clk(clk), .rst(rst),
    .s_cmd_hi(syn[B_CMD_HI]), .s_cmd_lo(syn[B_CMD_LO]),
    .s_hi_dis(syn[B_HI_DIS]), .s_lo_dis(syn[B_LO_DIS]),
    .s_main_uv(syn[B_MAIN_UV]), .s_float_uv(syn[B_FLT_UV]),
    .gate_hi_en(gate_hi_en), .gate_lo_en(gate_lo_en),
    .wait_nxt(wait_nxt)
  );

  generate
    if (TIMEOUT_EN != 0) begin : g_tmo
      hb_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst(rst), .waiting(wait_nxt), .fault(tmo_fault)
      );
    end else begin : g_no_tmo
      assign tmo_fault = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) uv_status <= 1'b1;
    else     uv_status <= syn[B_MAIN_UV];
  end

  p_fault_gates_off_r9: assert property (@(posedge clk) disable iff (rst)
    tmo_fault |-> (!gate_hi_en && !gate_lo_en));
endmodule

// File: tb/hb_interlock_tb.sv
module hb_interlock_tb;
  localparam int LIM = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_hi = 0, cmd_lo = 0, hi_dis = 0, lo_dis = 0, main_uv = 1, float_uv = 1;
  logic gate_hi_en, gate_lo_en, uv_status, tmo_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  hb_interlock #(.TIMEOUT_CYC(LIM)) u_dut (
    .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .hi_gate_dis(hi_dis), .lo_gate_dis(lo_dis),
    .main_uv(main_uv), .float_uv(float_uv),
    .gate_hi_en(gate_hi_en), .gate_lo_en(gate_lo_en),
    .uv_status(uv_status), .tmo_fault(tmo_fault)
  );

  // reference model: sync pipeline as two-entry shift of input words
  // word: {main_uv, float_uv, lo_dis, hi_dis, cmd_lo, cmd_hi}
  logic [5:0] ms1, ms2;
  int mst, mwc;
  logic e_hi, e_lo, e_uv, e_flt;

  always @(posedge clk) begin
    if (rst) begin
      ms1 = 6'b110000; ms2 = 6'b110000; mst = 0; mwc = 0;
      e_hi = 0; e_lo = 0; e_uv = 1; e_flt = 0;
    end else begin
      bit wt, wb, ch, cl, hd, ld, mu, fu;
      int ns;
      bit nw;
      ch = ms2[0]; cl = ms2[1]; hd = ms2[2]; ld = ms2[3]; fu = ms2[4]; mu = ms2[5];
      wt = ch && !cl && !mu && !fu;
      wb = cl && !ch && !mu;
      ns = mst;
      if (mst == 0) begin
        if (wt) ns = ld ? 2 : 1;
        else if (wb) ns = hd ? 4 : 3;
      end else if (mst == 1) begin
        if (!wt) ns = 0; else if (ld) ns = 2;
      end else if (mst == 2) begin
        if (!wt) ns = 0;
      end else if (mst == 3) begin
        if (!wb) ns = 0; else if (hd) ns = 4;
      end else begin
        if (!wb) ns = 0;
      end
      nw = (ns == 1) || (ns == 3);
      e_flt = nw && (mwc >= LIM);
      mwc = nw ? ((mwc < LIM) ? mwc + 1 : LIM) : 0;
      mst = ns;
      e_hi = (ns == 2);
      e_lo = (ns == 4);
      e_uv = mu;
      ms2 = ms1;
      ms1 = {main_uv, float_uv, lo_dis, hi_dis, cmd_lo, cmd_hi};
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "gate_hi_en", gate_hi_en, e_hi);
      chk(cur_req, "gate_lo_en", gate_lo_en, e_lo);
      chk("R7", "uv_status", uv_status, e_uv);
      chk("R9", "tmo_fault", tmo_fault, e_flt);
      checks++;
      if (gate_hi_en && gate_lo_en) begin
        errors++;
        $display("FAIL R1 both enables: actual=11 expected=not both at %0t", $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    @(posedge clk); #1;
    cur_req = "R10";
    chk("R10", "reset hi", gate_hi_en, 0);
    chk("R10", "reset lo", gate_lo_en, 0);
    chk("R10", "reset fault", tmo_fault, 0);
    chk("R10", "reset uv", uv_status, 1);
    @(negedge clk);
    main_uv = 0; float_uv = 0; hi_dis = 1; lo_dis = 1;
    cyc(5);

    // R2: each channel alone, then off
    cur_req = "R2";
    cmd_hi = 1; cyc(6);
    chk("R2", "hi alone", gate_hi_en, 1);
    cmd_hi = 0; cyc(6);
    chk("R2", "hi released", gate_hi_en, 0);
    cmd_lo = 1; hi_dis = 1; cyc(6);
    chk("R2", "lo alone", gate_lo_en, 1);
    cmd_lo = 0; cyc(6);

    // R8: exact latency of a command change
    cur_req = "R8";
    cmd_hi = 1; cyc(6);
    @(negedge clk) cmd_hi = 0;
    @(posedge clk); @(posedge clk); #1;
    chk("R8", "still on after 2 edges", gate_hi_en, 1);
    @(posedge clk); #1;
    chk("R8", "off after 3rd edge", gate_hi_en, 0);
    cyc(4);

    // R4: pending until opposite discharge flag
    cur_req = "R4";
    lo_dis = 0; cmd_hi = 1; cyc(10);
    chk("R4", "hi pending", gate_hi_en, 0);
    lo_dis = 1; cyc(5);
    chk("R4", "hi after flag", gate_hi_en, 1);
    // R3: swap high -> low with high gate slow to discharge
    cur_req = "R3";
    hi_dis = 0; cmd_hi = 0; cmd_lo = 1; cyc(8);
    chk("R3", "lo held while high not discharged", gate_lo_en, 0);
    hi_dis = 1; cyc(5);
    chk("R3", "lo after high discharged", gate_lo_en, 1);
    // direct swap low -> high with flags ready
    cmd_lo = 0; cmd_hi = 1; cyc(8);
    chk("R3", "hi after swap", gate_hi_en, 1);

    // R1: both commands high
    cur_req = "R1";
    cmd_lo = 1; cyc(6);
    chk("R1", "both cmds hi", gate_hi_en, 0);
    chk("R1", "both cmds lo", gate_lo_en, 0);
    cmd_lo = 0; cyc(6);

    // R5: main undervoltage kills both
    cur_req = "R5";
    main_uv = 1; cyc(6);
    chk("R5", "hi off under main uv", gate_hi_en, 0);
    chk("R7", "uv status set", uv_status, 1);
    cmd_hi = 0; cmd_lo = 1; cyc(6);
    chk("R5", "lo off under main uv", gate_lo_en, 0);
    main_uv = 0; cyc(6);
    chk("R7", "uv status cleared", uv_status, 0);

    // R6: floating undervoltage blocks high only
    cur_req = "R6";
    float_uv = 1; cyc(6);
    chk("R6", "lo keeps running", gate_lo_en, 1);
    cmd_lo = 0; cmd_hi = 1; cyc(8);
    chk("R6", "hi blocked", gate_hi_en, 0);
    float_uv = 0; cyc(6);
    chk("R6", "hi after float ok", gate_hi_en, 1);
    cmd_hi = 0; cyc(6);

    // R9: timeout on a stuck discharge flag
    cur_req = "R9";
    hi_dis = 0; cmd_lo = 1; cyc(LIM + 10);
    chk("R9", "fault after long wait", tmo_fault, 1);
    chk("R9", "lo still off", gate_lo_en, 0);
    hi_dis = 1; cyc(5);
    chk("R9", "fault cleared", tmo_fault, 0);
    chk("R9", "lo on after flag", gate_lo_en, 1);
    cmd_lo = 0; lo_dis = 0; cmd_hi = 1; cyc(LIM - 4);
    chk("R9", "no fault short wait", tmo_fault, 0);
    cmd_hi = 0; lo_dis = 1; cyc(8);

    finish_run();
  end
endmodule